// File: doc/BRIEF.md
# AXI4 Slave Burst and Region Decoder

This block is the AXI4 slave front end of a small accelerator's local storage. A bus master reaches three regions through it: an instruction store, a data store and a control register bank. Read and write bursts arrive on the five AXI4 channels. The block works out the byte address of every beat from the burst type, the beat size and the burst length. It decodes each beat into a region, and reads from or writes to that region's internal register array.

Every response beat carries the transaction ID that came with the request, and read beats carry LAST. A beat that lands outside the map, breaks its region's alignment rule, or asks for a beat wider than the bus gets an error response. Its write is discarded, and a read returns zero data.

Each direction handles one transaction at a time. The AR and AW channels stay closed until the current burst has finished. The protection, lock, cache, QoS, region and USER fields are not present at the ports.

Top module: `axi_mem_front`

## Requirements
- R1: Each beat's address follows from the previous one by burst type. FIXED (0) repeats the start address. INCR (1) steps to the size-aligned address plus 2^size bytes. WRAP (2) steps the same way but stays inside a window of (len+1)·2^size bytes, aligned to that window's size.
- R2: A read burst returns exactly len+1 beats, and LAST is set only on the final one.
- R3: R beats carry the ID accepted on AR, and the B response carries the ID accepted on AW. Both stay stable while the master stalls.
- R4: Response codes are limited to OKAY (2'b00) and SLVERR (2'b10).
- R5: The map has three regions. The instruction store is at 0x0000–0x1FFF, the data store at 0x10000–0x17FFF and the register bank at 0x30000–0x300FF. Each region holds 8 lines of 16 bytes, selected by bits [6:4] of the offset within the region, so higher offsets alias. Read data is the whole line, and byte lane b is data bits [8b+7:8b].
- R6: In the instruction store and the register bank, a beat whose address has bits [1:0] nonzero gets SLVERR. The data store accepts any byte address.
- R7: A beat outside all three regions, or with a size code above 4, gets SLVERR. Its write data is discarded and its read data is zero.
- R8: A write beat changes only the byte lanes whose strobe bit is set.
- R9: AR ready drops after an AR handshake and returns only after the final R beat has been accepted. AW ready drops after an AW handshake and returns only after B has been accepted.
- R10: B is raised only after the W beat carrying LAST has been accepted. Its code is SLVERR if any beat in the burst erred, and OKAY otherwise.
- R11: After reset, both address channels are ready, R and B are idle, and all three stores read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_id_i | input | ID_W | Write transaction ID |
| aw_addr_i | input | ADDR_W | Write start byte address |
| aw_len_i | input | 8 | Write beats minus one |
| aw_size_i | input | 3 | Write log2 bytes per beat |
| aw_burst_i | input | 2 | Write burst type |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_o | output | 1 | Write address ready |
| w_data_i | input | DATA_W | Write beat data |
| w_strb_i | input | DATA_W/8 | Write byte strobes |
| w_last_i | input | 1 | Final write beat |
| w_valid_i | input | 1 | Write data valid |
| w_ready_o | output | 1 | Write data ready |
| b_id_o | output | ID_W | Write response ID |
| b_resp_o | output | 2 | Write response code |
| b_valid_o | output | 1 | Write response valid |
| b_ready_i | input | 1 | Write response ready |
| ar_id_i | input | ID_W | Read transaction ID |
| ar_addr_i | input | ADDR_W | Read start byte address |
| ar_len_i | input | 8 | Read beats minus one |
| ar_size_i | input | 3 | Read log2 bytes per beat |
| ar_burst_i | input | 2 | Read burst type |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_o | output | 1 | Read address ready |
| r_id_o | output | ID_W | Read beat ID |
| r_data_o | output | DATA_W | Read beat data |
| r_resp_o | output | 2 | Read beat response code |
| r_last_o | output | 1 | Final read beat |
| r_valid_o | output | 1 | Read beat valid |
| r_ready_i | input | 1 | Read beat ready |

## Verification
A sweep over every burst type, every legal beat size and three lengths each writes a burst into the data store and reads it back.

- Unaligned INCR starts test the alignment step.
- WRAP windows of 2, 4 and 8 beats show whether wrapping happens at the right boundary rather than running on.
- FIXED bursts of several beats, with per-beat strobes, show whether later beats overwrite the same line lane by lane.

Directed bursts cover each region's alignment rule, the end of the register bank, an unmapped hole, an oversized beat, and an INCR burst that runs off the end of the instruction store. That last case separates per-beat error codes from the single accumulated write response.

// File: rtl/axi_front_pkg.sv
package axi_front_pkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2
  } burst_e;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_IMEM = 2'd1,
    RGN_DMEM = 2'd2,
    RGN_CSR  = 2'd3
  } rgn_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_DATA = 2'd1,
    WS_RESP = 2'd2
  } wr_st_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  localparam logic [31:0] IMEM_BASE = 32'h0000_0000;
  localparam logic [31:0] IMEM_SPAN = 32'h0000_2000;
  localparam logic [31:0] DMEM_BASE = 32'h0001_0000;
  localparam logic [31:0] DMEM_SPAN = 32'h0000_8000;
  localparam logic [31:0] CSR_BASE  = 32'h0003_0000;

endpackage

// File: rtl/beat_addr_gen.sv
module beat_addr_gen
  import axi_front_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        len_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        burst_i,
  output logic [ADDR_W-1:0] next_o
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] step, aligned, bumped, win_mask;

  always_comb begin
    step     = ONE << size_i;
    aligned  = addr_i & ~(step - ONE);
    bumped   = aligned + step;
    // window is a power of two for legal wrap lengths
    win_mask = ((ADDR_W'(len_i) + ONE) << size_i) - ONE;
    case (burst_i)
      BURST_INCR: next_o = bumped;
      BURST_WRAP: next_o = (addr_i & ~win_mask) | (bumped & win_mask);
      default:    next_o = addr_i;
    endcase
  end

endmodule

// File: rtl/region_decode.sv
module region_decode
  import axi_front_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 128,
  parameter int LINES    = 8,
  parameter int CSR_SPAN = 256,
  localparam int LANE_LSB = $clog2(DATA_W / 8),
  localparam int LINE_W   = $clog2(LINES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  output rgn_e              rgn_o,
  output logic              err_o,
  output logic [LINE_W-1:0] line_o
);

  logic [31:0] a32, base, off;
  logic        need_word, oversize;

  always_comb begin
    a32       = 32'(addr_i);
    rgn_o     = RGN_NONE;
    base      = '0;
    need_word = 1'b0;
    if (a32 >= IMEM_BASE && a32 < IMEM_BASE + IMEM_SPAN) begin
      rgn_o     = RGN_IMEM;
      base      = IMEM_BASE;
      need_word = 1'b1;
    end else if (a32 >= DMEM_BASE && a32 < DMEM_BASE + DMEM_SPAN) begin
      rgn_o = RGN_DMEM;
      base  = DMEM_BASE;
    end else if (a32 >= CSR_BASE && a32 < CSR_BASE + 32'(CSR_SPAN)) begin
      rgn_o     = RGN_CSR;
      base      = CSR_BASE;
      need_word = 1'b1;
    end
    off      = a32 - base;
    line_o   = LINE_W'(off >> LANE_LSB);
    oversize = 32'(size_i) > 32'(LANE_LSB);
    err_o    = (rgn_o == RGN_NONE) || oversize || (need_word && (a32[1:0] != 2'b00));
  end

endmodule

// File: rtl/region_mem.sv
module region_mem #(
  parameter int DATA_W = 128,
  parameter int LINES  = 8,
  localparam int STRB_W = DATA_W / 8,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LINE_W-1:0] wline_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LINE_W-1:0] rline_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < LINES; l++) mem_q[l] <= '0;
    end else if (we_i) begin
      for (int b = 0; b < STRB_W; b++)
        if (wstrb_i[b]) mem_q[wline_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign rdata_o = mem_q[rline_i];

endmodule

// File: rtl/axi_mem_front.sv
module axi_mem_front
  import axi_front_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 128,
  parameter int LINES    = 8,
  parameter int CSR_SPAN = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ID_W-1:0]     aw_id_i,
  input  logic [ADDR_W-1:0]   aw_addr_i,
  input  logic [7:0]          aw_len_i,
  input  logic [2:0]          aw_size_i,
  input  logic [1:0]          aw_burst_i,
  input  logic                aw_valid_i,
  output logic                aw_ready_o,
  input  logic [DATA_W-1:0]   w_data_i,
  input  logic [DATA_W/8-1:0] w_strb_i,
  input  logic                w_last_i,
  input  logic                w_valid_i,
  output logic                w_ready_o,
  output logic [ID_W-1:0]     b_id_o,
  output logic [1:0]          b_resp_o,
  output logic                b_valid_o,
  input  logic                b_ready_i,
  input  logic [ID_W-1:0]     ar_id_i,
  input  logic [ADDR_W-1:0]   ar_addr_i,
  input  logic [7:0]          ar_len_i,
  input  logic [2:0]          ar_size_i,
  input  logic [1:0]          ar_burst_i,
  input  logic                ar_valid_i,
  output logic                ar_ready_o,
  output logic [ID_W-1:0]     r_id_o,
  output logic [DATA_W-1:0]   r_data_o,
  output logic [1:0]          r_resp_o,
  output logic                r_last_o,
  output logic                r_valid_o,
  input  logic                r_ready_i
);

  localparam int N_RGN  = 3;
  localparam int LINE_W = $clog2(LINES);

  // ---------------- read side ----------------
  logic              rd_busy;
  logic [ADDR_W-1:0] rd_addr, rd_next;
  logic [7:0]        rd_len, rd_cnt;
  logic [2:0]        rd_size;
  logic [1:0]        rd_burst;
  logic [ID_W-1:0]   rd_id;
  rgn_e              rd_rgn;
  logic              rd_bad;
  logic [LINE_W-1:0] rd_line_idx;
  logic              ar_fire, r_fire;
  logic [DATA_W-1:0] rgn_rdata [N_RGN];

  assign ar_fire = ar_valid_i && ar_ready_o;
  assign r_fire  = r_valid_o && r_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_busy  <= 1'b0;
      rd_addr  <= '0;
      rd_len   <= '0;
      rd_cnt   <= '0;
      rd_size  <= '0;
      rd_burst <= '0;
      rd_id    <= '0;
    end else if (ar_fire) begin
      rd_busy  <= 1'b1;
      rd_addr  <= ar_addr_i;
      rd_len   <= ar_len_i;
      rd_cnt   <= '0;
      rd_size  <= ar_size_i;
      rd_burst <= ar_burst_i;
      rd_id    <= ar_id_i;
    end else if (r_fire) begin
      if (r_last_o) begin
        rd_busy <= 1'b0;
      end else begin
        rd_addr <= rd_next;
        rd_cnt  <= rd_cnt + 8'd1;
      end
    end
  end

  beat_addr_gen #(.ADDR_W(ADDR_W)) u_rd_agen (
    .addr_i (rd_addr),
    .len_i  (rd_len),
    .size_i (rd_size),
    .burst_i(rd_burst),
    .next_o (rd_next)
  );

  region_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .CSR_SPAN(CSR_SPAN)
  ) u_rd_dec (
    .addr_i(rd_addr),
    .size_i(rd_size),
    .rgn_o (rd_rgn),
    .err_o (rd_bad),
    .line_o(rd_line_idx)
  );

  assign ar_ready_o = !rd_busy;
  assign r_valid_o  = rd_busy;
  assign r_id_o     = rd_id;
  assign r_last_o   = (rd_cnt == rd_len);
  assign r_resp_o   = rd_bad ? RESP_SLVERR : RESP_OKAY;

  always_comb begin
    r_data_o = '0;
    if (!rd_bad) begin
      case (rd_rgn)
        RGN_IMEM: r_data_o = rgn_rdata[0];
        RGN_DMEM: r_data_o = rgn_rdata[1];
        RGN_CSR:  r_data_o = rgn_rdata[2];
        default:  r_data_o = '0;
      endcase
    end
  end

  // ---------------- write side ----------------
  wr_st_e            wr_st;
  logic [ADDR_W-1:0] wr_addr, wr_next;
  logic [7:0]        wr_len;
  logic [2:0]        wr_size;
  logic [1:0]        wr_burst;
  logic [ID_W-1:0]   wr_id;
  logic              wr_err_acc;
  rgn_e              wr_rgn;
  logic              wr_bad;
  logic [LINE_W-1:0] wr_line_idx;
  logic              aw_fire, w_fire, b_fire;

  assign aw_fire = aw_valid_i && aw_ready_o;
  assign w_fire  = w_valid_i && w_ready_o;
  assign b_fire  = b_valid_o && b_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_st      <= WS_IDLE;
      wr_addr    <= '0;
      wr_len     <= '0;
      wr_size    <= '0;
      wr_burst   <= '0;
      wr_id      <= '0;
      wr_err_acc <= 1'b0;
    end else begin
      case (wr_st)
        WS_IDLE: if (aw_fire) begin
          wr_st      <= WS_DATA;
          wr_addr    <= aw_addr_i;
          wr_len     <= aw_len_i;
          wr_size    <= aw_size_i;
          wr_burst   <= aw_burst_i;
          wr_id      <= aw_id_i;
          wr_err_acc <= 1'b0;
        end
        WS_DATA: if (w_fire) begin
          wr_err_acc <= wr_err_acc | wr_bad;
          wr_addr    <= wr_next;
          if (w_last_i) wr_st <= WS_RESP;
        end
        WS_RESP: if (b_fire) wr_st <= WS_IDLE;
        default: wr_st <= WS_IDLE;
      endcase
    end
  end

  beat_addr_gen #(.ADDR_W(ADDR_W)) u_wr_agen (
    .addr_i (wr_addr),
    .len_i  (wr_len),
    .size_i (wr_size),
    .burst_i(wr_burst),
    .next_o (wr_next)
  );

  region_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .CSR_SPAN(CSR_SPAN)
  ) u_wr_dec (
    .addr_i(wr_addr),
    .size_i(wr_size),
    .rgn_o (wr_rgn),
    .err_o (wr_bad),
    .line_o(wr_line_idx)
  );

  assign aw_ready_o = (wr_st == WS_IDLE);
  assign w_ready_o  = (wr_st == WS_DATA);
  assign b_valid_o  = (wr_st == WS_RESP);
  assign b_id_o     = wr_id;
  assign b_resp_o   = wr_err_acc ? RESP_SLVERR : RESP_OKAY;

  // ---------------- region storage ----------------
  for (genvar k = 0; k < N_RGN; k++) begin : g_rgn
    localparam rgn_e MY_RGN = rgn_e'(2'(k + 1));
    region_mem #(.DATA_W(DATA_W), .LINES(LINES)) u_mem (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (w_fire && !wr_bad && (wr_rgn == MY_RGN)),
      .wline_i(wr_line_idx),
      .wstrb_i(w_strb_i),
      .wdata_i(w_data_i),
      .rline_i(rd_line_idx),
      .rdata_o(rgn_rdata[k])
    );
  end

  // ---------------- assertions ----------------
  // R9
  ar_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_fire |=> !ar_ready_o);
  // R9
  aw_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_fire |=> !aw_ready_o);
  // R3
  r_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && !r_ready_i |=> r_valid_o && $stable(r_id_o) && $stable(r_last_o));
  // R3
  b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o && !b_ready_i |=> b_valid_o && $stable(b_id_o) && $stable(b_resp_o));
  // R10
  b_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_fire && w_last_i |=> b_valid_o && !w_ready_o);
  // R7
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && (r_resp_o == RESP_SLVERR) |-> (r_data_o == '0));
  // R1
  fixed_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_fire && !r_last_o && (rd_burst == BURST_FIXED) |=> $stable(rd_addr));
  // R2
  last_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_fire && r_last_o |=> !r_valid_o);

endmodule

// File: tb/sim_axi_mem_front.sv
module sim_axi_mem_front;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]   aw_id = '0, ar_id = '0;
  logic [19:0]  aw_addr = '0, ar_addr = '0;
  logic [7:0]   aw_len = '0, ar_len = '0;
  logic [2:0]   aw_size = '0, ar_size = '0;
  logic [1:0]   aw_burst = '0, ar_burst = '0;
  logic         aw_valid = 1'b0, ar_valid = 1'b0;
  logic [127:0] w_data = '0;
  logic [15:0]  w_strb = '0;
  logic         w_last = 1'b0, w_valid = 1'b0, b_ready = 1'b0, r_ready = 1'b0;
  logic         aw_ready, w_ready, b_valid, ar_ready, r_last, r_valid;
  logic [3:0]   b_id, r_id;
  logic [1:0]   b_resp, r_resp;
  logic [127:0] r_data;

  axi_mem_front u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .aw_id_i(aw_id), .aw_addr_i(aw_addr), .aw_len_i(aw_len), .aw_size_i(aw_size),
    .aw_burst_i(aw_burst), .aw_valid_i(aw_valid), .aw_ready_o(aw_ready),
    .w_data_i(w_data), .w_strb_i(w_strb), .w_last_i(w_last), .w_valid_i(w_valid),
    .w_ready_o(w_ready),
    .b_id_o(b_id), .b_resp_o(b_resp), .b_valid_o(b_valid), .b_ready_i(b_ready),
    .ar_id_i(ar_id), .ar_addr_i(ar_addr), .ar_len_i(ar_len), .ar_size_i(ar_size),
    .ar_burst_i(ar_burst), .ar_valid_i(ar_valid), .ar_ready_o(ar_ready),
    .r_id_o(r_id), .r_data_o(r_data), .r_resp_o(r_resp), .r_last_o(r_last),
    .r_valid_o(r_valid), .r_ready_i(r_ready)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] mdl [3][8][16];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // region, line and error per R5, R6, R7
  function automatic void dec(input logic [31:0] a, input int sz,
                              output int r, output int ln, output bit err);
    logic [31:0] base;
    r = -1; base = 0;
    if (a < 32'h2000) begin r = 0; base = 32'h0; end
    else if (a >= 32'h10000 && a < 32'h18000) begin r = 1; base = 32'h10000; end
    else if (a >= 32'h30000 && a < 32'h30100) begin r = 2; base = 32'h30000; end
    err = (r < 0) || (sz > 4) || ((r == 0 || r == 2) && a[1:0] != 2'b00);
    ln  = int'(((a - base) >> 4) & 32'd7);
  endfunction

  // next beat address per R1
  function automatic logic [31:0] nxt(input logic [31:0] a, input int len, input int sz, input int bt);
    logic [31:0] bytes, al, win, wbase, n;
    bytes = 32'd1 << sz;
    al    = a - (a % bytes);
    n     = al + bytes;
    if (bt == 0) n = a;
    else if (bt == 2) begin
      win   = 32'(len + 1) * bytes;
      wbase = a - (a % win);
      if (n >= wbase + win) n = wbase;
    end
    return n & 32'hFFFFF;
  endfunction

  function automatic logic [127:0] mk_data(input int seed, input int beat);
    logic [127:0] d;
    for (int b = 0; b < 16; b++) d[8*b +: 8] = 8'((seed * 29 + beat * 11 + b * 7) & 255);
    return d;
  endfunction

  function automatic logic [15:0] mk_strb(input int seed, input int beat);
    if (beat % 2 == 0) return 16'hFFFF;
    return 16'((seed * 5779 + beat * 40503) ^ 16'hF00F);
  endfunction

  function automatic logic [127:0] line_of(input int r, input int ln, input bit err);
    logic [127:0] d = '0;
    if (!err) for (int b = 0; b < 16; b++) d[8*b +: 8] = mdl[r][ln][b];
    return d;
  endfunction

  task automatic do_write(input logic [3:0] id, input logic [31:0] a, input int len, input int sz,
                          input int bt, input int seed, input int stbo, input string tag);
    logic [31:0] cur = a;
    bit any_err = 1'b0;
    int r, ln;
    bit err;
    @(negedge clk);
    aw_id = id; aw_addr = cur[19:0]; aw_len = 8'(len); aw_size = 3'(sz); aw_burst = 2'(bt);
    aw_valid = 1'b1;
    while (!aw_ready) @(negedge clk);
    @(negedge clk);
    aw_valid = 1'b0;
    for (int k = 0; k <= len; k++) begin
      w_data = mk_data(seed, k);
      w_strb = (stbo >= 0) ? 16'(stbo) : mk_strb(seed, k);
      w_last = (k == len);
      w_valid = 1'b1;
      while (!w_ready) @(negedge clk);
      chk("R9 aw_ready low in burst", 128'(aw_ready), 128'(0));
      dec(cur, sz, r, ln, err);
      any_err |= err;
      if (!err) for (int b = 0; b < 16; b++) if (w_strb[b]) mdl[r][ln][b] = w_data[8*b +: 8];
      cur = nxt(cur, len, sz, bt);
      @(negedge clk);
    end
    w_valid = 1'b0; w_last = 1'b0;
    b_ready = 1'b1;
    while (!b_valid) @(negedge clk);
    chk("R3 bid", 128'(b_id), 128'(id));
    // R4: only 00 or 10 expected
    chk({tag, " R10 bresp"}, 128'(b_resp), any_err ? 128'(2) : 128'(0));
    @(negedge clk);
    b_ready = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] id, input logic [31:0] a, input int len, input int sz,
                         input int bt, input bit stall, input string tag);
    logic [31:0] cur = a;
    int r, ln;
    bit err;
    @(negedge clk);
    ar_id = id; ar_addr = cur[19:0]; ar_len = 8'(len); ar_size = 3'(sz); ar_burst = 2'(bt);
    ar_valid = 1'b1;
    r_ready = 1'b1;
    while (!ar_ready) @(negedge clk);
    @(negedge clk);
    ar_valid = 1'b0;
    for (int k = 0; k <= len; k++) begin
      if (stall) begin
        r_ready = 1'b0;
        @(negedge clk);
        r_ready = 1'b1;
      end
      while (!r_valid) @(negedge clk);
      dec(cur, sz, r, ln, err);
      chk("R9 ar_ready low in burst", 128'(ar_ready), 128'(0));
      chk("R3 rid", 128'(r_id), 128'(id));
      chk("R2 rlast", 128'(r_last), 128'(k == len));
      chk({tag, " R4 rresp"}, 128'(r_resp), err ? 128'(2) : 128'(0));
      chk({tag, " data"}, r_data, line_of(r, ln, err));
      cur = nxt(cur, len, sz, bt);
      @(negedge clk);
    end
    r_ready = 1'b0;
    chk("R2 no extra beat", 128'(r_valid), 128'(0));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int r = 0; r < 3; r++) for (int l = 0; l < 8; l++) for (int b = 0; b < 16; b++)
      mdl[r][l][b] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ar_ready", 128'(ar_ready), 128'(1));
    chk("R11 aw_ready", 128'(aw_ready), 128'(1));
    chk("R11 r_valid", 128'(r_valid), 128'(0));
    chk("R11 b_valid", 128'(b_valid), 128'(0));
    do_read(4'h1, 32'h30020, 0, 2, 1, 1'b0, "R11 cleared csr");
    do_read(4'h2, 32'h10040, 3, 4, 1, 1'b0, "R11 cleared dmem");

    // sweep: burst type x size x length in the data store
    begin
      int idx = 0;
      for (int bt = 0; bt < 3; bt++)
        for (int sz = 0; sz < 5; sz++)
          for (int li = 0; li < 3; li++) begin
            int len;
            logic [31:0] st;
            len = (bt == 2) ? ((1 << (li + 1)) - 1) : li * 3;
            st  = 32'h10000 + 32'(idx * 128) + 32'((idx * 37) & 127);
            if (bt == 2) st = st & ~((32'd1 << sz) - 1);
            do_write(4'(idx), st, len, sz, bt, idx + 5, -1, "R1 R8 sweep");
            do_read(4'(idx + 3), st, len, sz, bt, (idx % 3) == 0, "R1 R8 sweep");
            idx++;
          end
    end

    do_write(4'h3, 32'h0100, 3, 2, 1, 77, -1, "R5 imem");
    do_read(4'h4, 32'h0100, 3, 2, 1, 1'b0, "R5 imem");
    do_write(4'h5, 32'h30040, 1, 3, 1, 78, -1, "R5 csr");
    do_read(4'h6, 32'h30040, 1, 3, 1, 1'b1, "R5 csr");
    do_write(4'h7, 32'h0102, 0, 1, 1, 79, -1, "R6 imem misaligned");
    do_read(4'h8, 32'h0102, 0, 1, 1, 1'b0, "R6 imem misaligned");
    do_read(4'h8, 32'h0100, 0, 2, 1, 1'b0, "R6 imem untouched");
    do_write(4'h9, 32'h10003, 2, 0, 1, 80, -1, "R6 dmem byte aligned");
    do_read(4'hA, 32'h10003, 2, 0, 1, 1'b0, "R6 dmem byte aligned");
    do_write(4'hB, 32'h30041, 0, 0, 0, 81, -1, "R6 csr misaligned");
    do_read(4'hB, 32'h30040, 0, 2, 0, 1'b0, "R6 csr untouched");
    do_write(4'hC, 32'h20000, 1, 2, 1, 82, -1, "R7 unmapped");
    do_read(4'hC, 32'h20000, 1, 2, 1, 1'b0, "R7 unmapped");
    do_write(4'hD, 32'h30100, 0, 2, 1, 83, -1, "R7 csr limit");
    do_read(4'hD, 32'h30100, 0, 2, 1, 1'b0, "R7 csr limit");
    do_write(4'hE, 32'h10000, 0, 5, 1, 84, -1, "R7 oversize");
    do_read(4'hE, 32'h10000, 0, 5, 1, 1'b0, "R7 oversize");
    do_read(4'hE, 32'h10000, 0, 4, 1, 1'b0, "R7 oversize untouched");
    do_write(4'hF, 32'h1FF8, 3, 2, 1, 85, -1, "R10 partial error");
    do_read(4'h0, 32'h1FF8, 3, 2, 1, 1'b1, "R10 partial error");
    do_write(4'h6, 32'h10200, 0, 4, 1, 86, 16'h0081, "R8 two lanes");
    do_read(4'h6, 32'h10200, 0, 4, 1, 1'b0, "R8 two lanes");
    do_write(4'h7, 32'h10200, 0, 4, 1, 87, 0, "R8 no lanes");
    do_read(4'h7, 32'h10200, 0, 4, 1, 1'b0, "R8 no lanes");

    repeat (2) @(negedge clk);
    summary();
  end

endmodule